// File: doc/BRIEF.md
# Minute-second countdown watchdog timer

This block is a watchdog timer reached through a byte-wide register bus. Its timeout is kept as two separate byte counters, one for minutes and one for seconds, which count down together once per second. When the seconds counter runs out it borrows from the minutes counter. Software loads a timeout of T seconds as T / 60 minutes and T mod 60 seconds, then writes a start command to the control register. To keep the system alive it repeats that sequence before the count runs out.

The loaded minutes and seconds are held in a shadow copy. Each start command reloads the live counters from that copy and restarts the one-second prescaler. Both live counters can be read while the timer runs, so software can compute the time left as minutes × 60 + seconds. On the first one-second tick after the count has reached 0:00, the block raises a reset request for one clock and stops itself.

Top module: `mmss_watchdog`

## Requirements
- R1: After reset the control register (address 0x06) reads 0x00, the minutes register (address 0x07) reads 1 and the seconds register (address 0x08) reads 0, and `expire_pulse` is low.
- R2: Writing 0x01 to address 0x06 starts the timer and copies the shadow minutes and seconds into the live counters. Writing 0x00 there stops the timer. Reading 0x06 returns the run state in bit 0, with bits 7..1 reading zero.
- R3: Writing any value other than 0x00 or 0x01 to address 0x06 leaves the run state unchanged.
- R4: While the timer is stopped, writes to 0x07 and 0x08 change only the shadow copy, and reads of 0x07 and 0x08 keep returning the old live values.
- R5: While the timer runs, a write to 0x07 or 0x08 updates both the shadow copy and the matching live counter at once.
- R6: While the timer runs, a tick occurs every TICK_DIV clock cycles. The first tick lands on the TICK_DIV-th rising edge after the edge that accepted the start command.
- R7: On a tick, if seconds is nonzero it decreases by one. If seconds is zero and minutes is nonzero, seconds becomes 59 and minutes decreases by one.
- R8: On a tick with both counters at zero, `expire_pulse` goes high for exactly one clock and the timer stops. A timeout of T seconds therefore expires on tick T+1.
- R9: Rewriting the timeout registers and then writing 0x01 again reloads the count and restarts the prescaler, which postpones expiry (keep-alive).
- R10: While the timer is stopped, the live counters keep their values.
- R11: A read of any address other than 0x06, 0x07 or 0x08 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| expire_pulse | output | 1 | One-clock reset request on expiry |

## Verification
The bound checker watches four things on every clock cycle: the plain decrement, the borrow from minutes into seconds, that the reset request lasts a single cycle and stops the timer, and that the counters hold still while the timer is stopped. Only the bench's scenarios can show the rest. That covers the exact cycle on which expiry lands, the split between the shadow copy and the live counters across start commands, keep-alive postponing expiry, control values that are ignored, and the read map. The bench scenarios also cover live writes while the timer runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ADDR_CTRL = 8'h06;
    localparam logic [BYTE_W-1:0] ADDR_MINS = 8'h07;
    localparam logic [BYTE_W-1:0] ADDR_SECS = 8'h08;

    localparam logic [BYTE_W-1:0] CMD_RUN  = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_HALT = 8'h00;

    localparam logic [BYTE_W-1:0] SEC_TOP = 8'd59;

    typedef struct packed {
        logic [BYTE_W-1:0] mins;
        logic [BYTE_W-1:0] secs;
    } mmss_t;

    localparam mmss_t RESET_TIMEOUT = '{mins: 8'd1, secs: 8'd0};

    typedef struct packed {
        logic run;
        logic halt;
        logic set_mins;
        logic set_secs;
    } bus_cmd_t;

    function automatic logic mmss_is_zero(mmss_t c);
        return (c.mins == '0) && (c.secs == '0);
    endfunction

    function automatic mmss_t mmss_step(mmss_t c);
        mmss_t n;
        n = c;
        if (c.secs != '0) begin
            n.secs = c.secs - 1'b1;
        end else begin
            n.secs = SEC_TOP;
            n.mins = c.mins - 1'b1;
        end
        return n;
    endfunction
endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
(
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              run_state,
    input  mmss_t             live,
    output bus_cmd_t          cmd,
    output logic [BYTE_W-1:0] rd_data
);
    always_comb begin
        cmd          = '0;
        cmd.run      = wr_en && (addr == ADDR_CTRL) && (wr_data == CMD_RUN);
        cmd.halt     = wr_en && (addr == ADDR_CTRL) && (wr_data == CMD_HALT);
        cmd.set_mins = wr_en && (addr == ADDR_MINS);
        cmd.set_secs = wr_en && (addr == ADDR_SECS);
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rd_data = {{(BYTE_W-1){1'b0}}, run_state};
            ADDR_MINS: rd_data = live.mins;
            ADDR_SECS: rd_data = live.secs;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int TICK_DIV = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !active) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = active && !restart && (phase_q == LAST);
endmodule

// File: rtl/wdt_mmss_counter.sv
module wdt_mmss_counter
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tick,
    output logic              run_q,
    output mmss_t             live_q,
    output logic              expire_q
);
    mmss_t shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RESET_TIMEOUT;
        end else begin
            if (cmd.set_mins) shadow_q.mins <= wr_data;
            if (cmd.set_secs) shadow_q.secs <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= RESET_TIMEOUT;
            run_q    <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (cmd.run) begin
                run_q  <= 1'b1;
                live_q <= shadow_q;
            end else if (cmd.halt) begin
                run_q <= 1'b0;
            end else if (run_q && (cmd.set_mins || cmd.set_secs)) begin
                if (cmd.set_mins) live_q.mins <= wr_data;
                if (cmd.set_secs) live_q.secs <= wr_data;
            end else if (tick) begin
                if (mmss_is_zero(live_q)) begin
                    expire_q <= 1'b1;
                    run_q    <= 1'b0;
                end else begin
                    live_q <= mmss_step(live_q);
                end
            end
        end
    end
endmodule

// File: rtl/mmss_watchdog.sv
module mmss_watchdog
    import wdt_pkg::*;
#(
    parameter int TICK_DIV = 250_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              expire_pulse
);
    bus_cmd_t cmd;
    logic     run_q;
    mmss_t    live_q;
    logic     tick;

    wdt_bus_decode u_decode (
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .run_state (run_q),
        .live      (live_q),
        .cmd       (cmd),
        .rd_data   (rd_data)
    );

    wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .active  (run_q),
        .restart (cmd.run),
        .tick    (tick)
    );

    wdt_mmss_counter u_count (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wr_data  (wr_data),
        .tick     (tick),
        .run_q    (run_q),
        .live_q   (live_q),
        .expire_q (expire_pulse)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_en,
    input logic  run_q,
    input logic  tick,
    input logic  expire,
    input mmss_t live
);
    assert_sec_decrement_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && live.secs != '0) |=> (live.secs == $past(live.secs) - 8'd1));

    assert_minute_borrow_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && live.secs == '0 && live.mins != '0)
            |=> (live.secs == SEC_TOP && live.mins == $past(live.mins) - 8'd1));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    assert_expire_stops_R8: assert property (@(posedge clk) disable iff (rst)
        expire |-> !run_q);

    assert_frozen_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !wr_en) |=> $stable(live));
endmodule

bind mmss_watchdog wdt_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .run_q  (run_q),
    .tick   (tick),
    .expire (expire_pulse),
    .live   (live_q)
);

// File: tb/mmss_watchdog_tb.sv
module mmss_watchdog_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       expire_pulse;

    always #2 clk = ~clk;

    mmss_watchdog #(.TICK_DIV(DIV)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .expire_pulse (expire_pulse)
    );

    int    cyc = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    int    pulses = 0;
    int    pulse_cyc = -1;
    int    en_edge = 0;
    int    ref_edge = 0;
    int    ref_t = 0;
    int    last_wr = 0;
    logic  mon_req = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: counts pulses and compares read data with queued expectations
    always @(negedge clk) begin
        if (expire_pulse) begin
            pulses++;
            pulse_cyc = cyc;
        end
        if (mon_req && exp_q.size() > 0) begin
            check(int'(rd_data), int'(exp_q.pop_front()), tag_q.pop_front());
        end
    end

    function automatic int remaining(input int c);
        return ref_t - ((c - en_edge) / DIV - (ref_edge - en_edge) / DIV);
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        last_wr = cyc;
    endtask

    task automatic start_timer(input int t);
        bus_write(8'h01 == 8'h01 ? 8'h06 : 8'h06, 8'h01);
        en_edge = last_wr; ref_edge = last_wr; ref_t = t;
    endtask

    // kind 0: fixed value, 1: live minutes, 2: live seconds
    task automatic read_chk(input logic [7:0] a, input int kind, input int val, input string tag);
        int rem;
        @(posedge clk); #1;
        addr = a;
        rem = remaining(cyc);
        if (kind == 1)      exp_q.push_back(8'(rem / 60));
        else if (kind == 2) exp_q.push_back(8'(rem % 60));
        else                exp_q.push_back(8'(val));
        tag_q.push_back(tag);
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int hold;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        read_chk(8'h06, 0, 0, "R1 ctrl");
        read_chk(8'h07, 0, 1, "R1 mins");
        read_chk(8'h08, 0, 0, "R1 secs");
        check(pulses, 0, "R1 no pulse");

        // R4 writes while stopped touch only the shadow copy
        bus_write(8'h07, 8'd2);
        bus_write(8'h08, 8'd5);
        read_chk(8'h07, 0, 1, "R4 mins unchanged");
        read_chk(8'h08, 0, 0, "R4 secs unchanged");

        // R11 unmapped address
        read_chk(8'h09, 0, 0, "R11 unmapped");
        read_chk(8'h05, 0, 0, "R11 unmapped low");

        // R3 ignored control value while stopped
        bus_write(8'h06, 8'h05);
        read_chk(8'h06, 0, 0, "R3 ctrl stays off");

        // R2 start loads shadow 2:05 (125 s)
        start_timer(125);
        read_chk(8'h06, 0, 1, "R2 ctrl on");
        read_chk(8'h07, 1, 0, "R2 mins reload");
        read_chk(8'h08, 2, 0, "R6 secs first");
        repeat (6) @(posedge clk);
        read_chk(8'h08, 2, 0, "R6 secs after ticks");
        repeat (10) @(posedge clk);
        read_chk(8'h07, 1, 0, "R7 mins after borrow");
        read_chk(8'h08, 2, 0, "R7 secs after borrow");

        // R3 ignored control value while running
        bus_write(8'h06, 8'h80);
        read_chk(8'h06, 0, 1, "R3 ctrl stays on");
        read_chk(8'h08, 2, 0, "R3 no reload");

        // R5 live write while running
        bus_write(8'h08, 8'd30);
        ref_t = remaining(last_wr - 1);
        ref_t = (ref_t / 60) * 60 + 30;
        ref_edge = last_wr;
        read_chk(8'h08, 2, 0, "R5 live secs");
        read_chk(8'h07, 1, 0, "R5 mins kept");

        // R10 stop freezes counters
        bus_write(8'h06, 8'h00);
        hold = remaining(last_wr - 1);
        read_chk(8'h06, 0, 0, "R2 ctrl off");
        repeat (20) @(posedge clk);
        read_chk(8'h08, 0, hold % 60, "R10 secs frozen");
        read_chk(8'h07, 0, hold / 60, "R10 mins frozen");

        // R8 expiry of a 2 s timeout on tick 3
        bus_write(8'h07, 8'd0);
        bus_write(8'h08, 8'd2);
        pulses = 0;
        start_timer(2);
        while (cyc < en_edge + 3 * DIV + 4) @(posedge clk);
        check(pulses, 1, "R8 one pulse");
        check(pulse_cyc - en_edge, 3 * DIV, "R8 pulse timing");
        read_chk(8'h06, 0, 0, "R8 stopped");

        // R9 keep-alive postpones expiry
        pulses = 0;
        start_timer(2);
        repeat (1) @(posedge clk);
        bus_write(8'h07, 8'd0);
        bus_write(8'h08, 8'd2);
        start_timer(2);
        while (cyc < en_edge + 3 * DIV + 4) @(posedge clk);
        check(pulses, 1, "R9 single pulse");
        check(pulse_cyc - en_edge, 3 * DIV, "R9 pulse after reload");

        finish_up();
    end
endmodule